// File: doc/BRIEF.md
# I2C EEPROM Transaction Sequencer

This block turns random-access read and write requests for a serial EEPROM with 16-bit memory addressing into ordered command sequences for a byte-level I2C master engine. A host presents one request per pulse: the direction, the memory address, a byte count and, for writes, the payload as a packed vector. The block answers the next cycle with an accept or refusal code. It then drives the engine one command at a time and follows the engine's completion, access-ready and stop-detected events.

A write is a single transfer: device address, the two memory-address bytes, the payload, then a stop. A read is done in two phases. The first is an address-setup phase that ends without a stop, and its completion is taken from the engine's access-ready event. The second is a repeated-start receive phase that ends with a stop. If the target NACKs during setup, the block clears the engine's NACK flag, forces a stop and, once that stop is confirmed, runs the setup again. A parameter bounds the number of these retries. Received bytes are held internally and handed to the host once the final stop is confirmed.

Byte counts above `MAX_BYTES` are clamped to `MAX_BYTES` when the request is accepted. Any engine event that the current step does not expect sets a sticky protocol-error flag, and the block then stops the bus and goes idle.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: After reset, status is 0 (inactive), `cmd_valid`, `nack_clr`, `rd_valid`, `rsp_valid` and `proto_err` are all 0.
- R2: An accepted write issues, one command per engine completion: START (op 1) with byte {DEV_ADDR,0} (0xA0 by default), WRITE (op 3) of the address high byte, WRITE of the low byte, one WRITE per payload byte in order (byte k taken from `req_wdata[8k+7:8k]`), then STOP (op 5).
- R3: An accepted read first issues START with {DEV_ADDR,0}, then WRITEs the address high byte and the low byte, and issues no STOP; it then waits for `ev_ardy`.
- R4: On `ev_ardy` with `eng_nack` low during setup, the block issues RESTART (op 2) with {DEV_ADDR,1} (0xA1 by default), then one READ (op 4) per requested byte, then STOP.
- R5: Every READ command carries `cmd_ack`=1 except the last READ of the request, which carries `cmd_ack`=0.
- R6: On `ev_ardy` with `eng_nack` high during setup, the block issues STOP with `nack_clr`=1 in the same cycle. On the following `ev_stop` it restarts the setup phase at START without checking `bus_busy`.
- R7: When the setup phase has been NACKed RETRY_MAX+1 times (RETRY_MAX retries), the final `ev_stop` ends the request with status 5 (NACK failure). No RESTART is issued.
- R8: Every `req_valid` pulse gets one `rsp_valid` pulse on the next cycle. `rsp_code` is 0 when the request is accepted and 3 when a sequence is still in progress.
- R9: While a commanded STOP has not yet been confirmed by `ev_stop`, a new request is refused with code 1. This takes priority over the bus-busy refusal.
- R10: While `bus_busy` is high and no stop is pending, a new request is refused with code 2, and no command is issued.
- R11: Status reads 1 (write busy) from acceptance until the write's `ev_stop`. For a read it reads 2 (address setup), then 3 (repeated start pending) from a clean `ev_ardy`, then 4 (receiving) from the RESTART completion, and returns to 0 on the read's `ev_stop`.
- R12: After a read's `ev_stop`, the received bytes appear on `rd_data` with `rd_valid` high, one per cycle, in the order they arrived.
- R13: An `ev_byte`, `ev_ardy` or `ev_stop` that the current step does not expect sets `proto_err`, which stays set until reset. The block then issues STOP (unless one is already pending) and returns to idle with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 16 | EEPROM memory address |
| req_len | input | LW | Byte count, clamped to MAX_BYTES |
| req_wdata | input | MAX_BYTES*8 | Write payload, byte k at bits 8k+7:8k |
| rsp_valid | output | 1 | Response pulse, one cycle after req_valid |
| rsp_code | output | 2 | 0 accepted, 1 stop not ready, 2 bus busy, 3 active |
| status | output | 3 | 0 inactive, 1 write busy, 2 setup, 3 restart pending, 4 receiving, 5 NACK failure |
| proto_err | output | 1 | Sticky protocol-error flag |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Engine command strobe |
| cmd_op | output | 3 | 1 START, 2 RESTART, 3 WRITE, 4 READ, 5 STOP |
| cmd_byte | output | 8 | Address or data byte for the command |
| cmd_ack | output | 1 | For READ: 1 = acknowledge, 0 = NACK |
| nack_clr | output | 1 | Clears the engine's NACK flag |
| ev_byte | input | 1 | Engine finished a START, RESTART, WRITE or READ |
| ev_ardy | input | 1 | Engine access-ready event |
| ev_stop | input | 1 | Engine stop-detected event |
| eng_nack | input | 1 | Engine sticky NACK flag |
| eng_rdata | input | 8 | Byte received by the engine |
| bus_busy | input | 1 | Bus busy level |

## Verification
The embedded assertions check several rules on every cycle. A NACK clear only accompanies a stop issued right after a NACKed access-ready. A repeated start only follows a clean access-ready. No fresh start is issued while a stop is unconfirmed. The only stop allowed during address setup is the NACK-forced one. The protocol-error flag never drops. Released read data never overlaps with a command or a pending stop.

Other properties need whole transactions and can only be shown by the directed scenarios against an engine-and-EEPROM model. These are the exact command order and bytes of writes and reads, the ACK/NACK pattern on received bytes, the retry count and final NACK-failure status, the data order on release, and the refusal codes under stop-pending, bus-busy and active conditions.

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         MAX_BYTES = 8,
  parameter int         RETRY_MAX = 8,
  localparam int        LW = $clog2(MAX_BYTES + 1),
  localparam int        DW = MAX_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_read,
  input  logic [15:0]   req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [2:0]    status,
  output logic          proto_err,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          cmd_valid,
  output logic [2:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_ack,
  output logic          nack_clr,
  input  logic          ev_byte,
  input  logic          ev_ardy,
  input  logic          ev_stop,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rdata,
  input  logic          bus_busy
);

  localparam int IW = $clog2(MAX_BYTES + 4);
  localparam int BW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int RW = $clog2(RETRY_MAX + 1);

  localparam logic [2:0] OP_START = 3'd1, OP_RESTART = 3'd2, OP_WRITE = 3'd3,
                         OP_READ  = 3'd4, OP_STOP    = 3'd5;
  localparam logic [2:0] ST_INACT = 3'd0, ST_WBUSY = 3'd1, ST_SETUP = 3'd2,
                         ST_RSTRT = 3'd3, ST_RBUSY = 3'd4, ST_NFAIL = 3'd5;
  localparam logic [1:0] RC_OK = 2'd0, RC_STOP = 2'd1, RC_BUSY = 2'd2, RC_ACT = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_WSEQ, S_WWAIT, S_SSEQ, S_SWAIT, S_SARDY, S_SNSTOP,
    S_SSTOP, S_RSEQ, S_RWAIT, S_RSTOP, S_DRAIN, S_ABORT
  } st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [LW-1:0] len_q;
  logic [15:0]   addr_q;
  logic [RW-1:0] retry_q;
  logic          stop_pend;
  logic [2:0]    stat_q;
  logic [7:0]    wbuf [MAX_BYTES];
  logic [7:0]    rbuf [MAX_BYTES];

  wire [IW-1:0] len_x  = IW'(len_q);
  wire [IW-1:0] pay_i  = idx - IW'(3);
  wire [IW-1:0] rcv_i  = idx - IW'(2);
  wire [LW-1:0] len_in = (req_len > LW'(MAX_BYTES)) ? LW'(MAX_BYTES) : req_len;

  wire exp_byte = (st == S_WWAIT) || (st == S_SWAIT) || (st == S_RWAIT);
  wire err = (st != S_ABORT) &&
             ((ev_byte && !exp_byte) || (ev_ardy && st != S_SARDY) || (ev_stop && !stop_pend));
  wire accept = req_valid && st == S_IDLE && !err && !stop_pend && !bus_busy;

  assign status   = stat_q;
  assign rd_valid = (st == S_DRAIN);
  assign rd_data  = rbuf[idx[BW-1:0]];

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
    cmd_byte  = 8'h00;
    cmd_ack   = 1'b0;
    nack_clr  = 1'b0;
    case (st)
      S_WSEQ, S_SSEQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        if (idx == '0) begin
          cmd_op   = OP_START;
          cmd_byte = {DEV_ADDR, 1'b0};
        end else if (idx == IW'(1)) cmd_byte = addr_q[15:8];
        else if (idx == IW'(2))     cmd_byte = addr_q[7:0];
        else if (idx < len_x + IW'(3)) cmd_byte = wbuf[pay_i[BW-1:0]];
        else cmd_op = OP_STOP;
      end
      S_SNSTOP: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_STOP;
        nack_clr  = 1'b1;
      end
      S_RSEQ: begin
        cmd_valid = 1'b1;
        if (idx == '0) begin
          cmd_op   = OP_RESTART;
          cmd_byte = {DEV_ADDR, 1'b1};
        end else if (idx <= len_x) begin
          cmd_op  = OP_READ;
          cmd_ack = (idx != len_x);
        end else cmd_op = OP_STOP;
      end
      S_ABORT: begin
        cmd_valid = !stop_pend;
        cmd_op    = stop_pend ? 3'd0 : OP_STOP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (accept && !req_read)
      for (int k = 0; k < MAX_BYTES; k++) wbuf[k] <= req_wdata[8*k +: 8];
    if (st == S_RWAIT && ev_byte && idx >= IW'(2))
      rbuf[rcv_i[BW-1:0]] <= eng_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      len_q     <= '0;
      addr_q    <= '0;
      retry_q   <= '0;
      stop_pend <= 1'b0;
      stat_q    <= ST_INACT;
      proto_err <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_code  <= RC_OK;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (st != S_IDLE || err) rsp_code <= RC_ACT;
        else if (stop_pend)      rsp_code <= RC_STOP;
        else if (bus_busy)       rsp_code <= RC_BUSY;
        else                     rsp_code <= RC_OK;
      end

      if (cmd_valid && cmd_op == OP_STOP) stop_pend <= 1'b1;
      else if (ev_stop)                   stop_pend <= 1'b0;

      if (err) begin
        proto_err <= 1'b1;
        stat_q    <= ST_INACT;
        st        <= S_ABORT;
      end else begin
        case (st)
          S_IDLE: begin
            if (accept) begin
              addr_q  <= req_addr;
              len_q   <= len_in;
              idx     <= '0;
              retry_q <= '0;
              st      <= req_read ? S_SSEQ : S_WSEQ;
              stat_q  <= req_read ? ST_SETUP : ST_WBUSY;
            end else if (ev_stop && stat_q == ST_WBUSY) stat_q <= ST_INACT;
          end
          S_WSEQ: begin
            idx <= idx + IW'(1);
            st  <= (cmd_op == OP_STOP) ? S_IDLE : S_WWAIT;
          end
          S_WWAIT: if (ev_byte) st <= S_WSEQ;
          S_SSEQ: begin
            idx <= idx + IW'(1);
            st  <= S_SWAIT;
          end
          S_SWAIT: if (ev_byte) st <= (idx == IW'(3)) ? S_SARDY : S_SSEQ;
          S_SARDY: if (ev_ardy) begin
            if (eng_nack) st <= S_SNSTOP;
            else begin
              idx    <= '0;
              stat_q <= ST_RSTRT;
              st     <= S_RSEQ;
            end
          end
          S_SNSTOP: st <= S_SSTOP;
          S_SSTOP: if (ev_stop) begin
            if (retry_q == RW'(RETRY_MAX)) begin
              stat_q <= ST_NFAIL;
              st     <= S_IDLE;
            end else begin
              retry_q <= retry_q + RW'(1);
              idx     <= '0;
              st      <= S_SSEQ;
            end
          end
          S_RSEQ: begin
            idx <= idx + IW'(1);
            st  <= (cmd_op == OP_STOP) ? S_RSTOP : S_RWAIT;
          end
          S_RWAIT: if (ev_byte) begin
            if (idx == IW'(1)) stat_q <= ST_RBUSY;
            st <= S_RSEQ;
          end
          S_RSTOP: if (ev_stop) begin
            stat_q <= ST_INACT;
            idx    <= '0;
            st     <= (len_q == '0) ? S_IDLE : S_DRAIN;
          end
          S_DRAIN: begin
            idx <= idx + IW'(1);
            if (idx == len_x - IW'(1)) st <= S_IDLE;
          end
          S_ABORT: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R6: the NACK clear only travels with a stop
  a_r6_clear_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nack_clr |-> (cmd_valid && cmd_op == OP_STOP));

  // R6: the NACK clear answers a NACKed access-ready of the cycle before
  a_r6_clear_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    nack_clr |-> $past(ev_ardy && eng_nack));

  // R4: a repeated start only follows a clean access-ready
  a_r4_restart_after_ardy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RESTART) |-> $past(ev_ardy && !eng_nack));

  // R9: no fresh start while a stop is unconfirmed
  a_r9_no_start_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_START) |-> !stop_pend);

  // R3: during setup the only stop is the NACK-forced one
  a_r3_setup_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STOP && status == ST_SETUP) |-> nack_clr);

  // R13: the protocol-error flag is sticky
  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R12: released data never overlaps a command or a pending stop
  a_r12_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cmd_valid && !stop_pend));

endmodule

// File: tb/tb_i2c_eeprom_seq.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_seq;
  localparam int MAXB = 8;
  localparam int RMAX = 8;
  localparam int LW = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid, req_read;
  logic [15:0]   req_addr;
  logic [LW-1:0] req_len;
  logic [MAXB*8-1:0] req_wdata;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic [2:0]    status;
  logic          proto_err, rd_valid;
  logic [7:0]    rd_data;
  logic          cmd_valid, cmd_ack, nack_clr;
  logic [2:0]    cmd_op;
  logic [7:0]    cmd_byte;
  logic          ev_byte, ev_ardy, ev_stop, eng_nack;
  logic [7:0]    eng_rdata;
  logic          eng_busy, ext_busy;
  logic          bus_busy;
  assign bus_busy = eng_busy | ext_busy;

  i2c_eeprom_seq #(.DEV_ADDR(7'h50), .MAX_BYTES(MAXB), .RETRY_MAX(RMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .status(status),
    .proto_err(proto_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .cmd_ack(cmd_ack), .nack_clr(nack_clr), .ev_byte(ev_byte),
    .ev_ardy(ev_ardy), .ev_stop(ev_stop), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata), .bus_busy(bus_busy));

  int n_chk = 0, n_fail = 0;
  int pend_cnt = 0, pend_kind = 0, ardy_cnt = 0, nack_left = 0, stop_lat = 3, wcnt = 0;
  logic inj_ardy = 1'b0;
  logic [7:0] mem [256];
  logic [15:0] ptr = 16'h0;
  int log_n = 0, clr_n = 0, rd_n = 0;
  logic [2:0] log_op [64];
  logic [7:0] log_b [64];
  logic log_ack [64];
  logic [7:0] rd_cap [16];
  logic [7:0] seen_stat = 8'h0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int count_op(input logic [2:0] op);
    int c = 0;
    for (int i = 0; i < log_n && i < 64; i++) if (log_op[i] == op) c++;
    return c;
  endfunction

  // engine and EEPROM model
  initial begin
    ev_byte = 0; ev_ardy = 0; ev_stop = 0; eng_nack = 0; eng_rdata = 0; eng_busy = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    forever begin
      @(negedge clk);
      ev_byte = 0; ev_ardy = 0; ev_stop = 0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          if (pend_kind == 2) begin ev_stop = 1; eng_busy = 0; end
          else begin ev_byte = 1; ardy_cnt = 4; end
        end
      end else if (ardy_cnt > 0) begin
        ardy_cnt--;
        if (ardy_cnt == 0) ev_ardy = 1;
      end
      if (inj_ardy) begin ev_ardy = 1; inj_ardy = 0; end
      if (nack_clr) begin eng_nack = 0; clr_n++; end
      if (cmd_valid) begin
        ardy_cnt = 0;
        if (log_n < 64) begin
          log_op[log_n] = cmd_op; log_b[log_n] = cmd_byte; log_ack[log_n] = cmd_ack;
        end
        log_n++;
        pend_kind = 1; pend_cnt = 3;
        case (cmd_op)
          3'd1: begin
            eng_busy = 1; wcnt = 0;
            if (!cmd_byte[0] && nack_left > 0) begin eng_nack = 1; nack_left--; end
          end
          3'd3: begin
            if (wcnt == 0) ptr[15:8] = cmd_byte;
            else if (wcnt == 1) ptr[7:0] = cmd_byte;
            else begin mem[ptr[7:0]] = cmd_byte; ptr++; end
            wcnt++;
          end
          3'd4: begin eng_rdata = mem[ptr[7:0]]; ptr++; end
          3'd5: begin pend_kind = 2; pend_cnt = stop_lat; end
          default: ;
        endcase
      end
    end
  end

  initial forever begin
    @(negedge clk);
    seen_stat[status] = 1'b1;
    if (rd_valid && rd_n < 16) begin rd_cap[rd_n] = rd_data; rd_n++; end
  end

  task automatic clear_log();
    log_n = 0; clr_n = 0; rd_n = 0; seen_stat = 8'h0;
  endtask

  task automatic send(input logic rd, input logic [15:0] a, input int len, output logic [1:0] code);
    @(negedge clk);
    req_valid = 1; req_read = rd; req_addr = a; req_len = LW'(len);
    @(negedge clk);
    req_valid = 0;
    chk("R8 response pulse", rsp_valid, 1);
    code = rsp_code;
  endtask

  task automatic wait_quiet();
    int k = 0;
    do begin @(negedge clk); k++; end
    while (k < 3000 && (status inside {3'd1, 3'd2, 3'd3, 3'd4} || eng_busy || pend_cnt != 0));
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 nack_clr", nack_clr, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 proto_err", proto_err, 0);
  endtask

  task automatic t_write();
    logic [1:0] c;
    clear_log();
    req_wdata = 64'h0000_0000_D4C3_B2A1;
    send(0, 16'h0012, 4, c);
    chk("R8 write accepted", c, 0);
    chk("R11 write busy", status, 1);
    wait_quiet();
    chk("R2 command count", log_n, 8);
    chk("R2 start op", log_op[0], 1);
    chk("R2 start byte", log_b[0], 8'hA0);
    chk("R2 addr hi", {log_op[1], log_b[1]}, {3'd3, 8'h00});
    chk("R2 addr lo", {log_op[2], log_b[2]}, {3'd3, 8'h12});
    chk("R2 payload 0", {log_op[3], log_b[3]}, {3'd3, 8'hA1});
    chk("R2 payload 3", {log_op[6], log_b[6]}, {3'd3, 8'hD4});
    chk("R2 stop", log_op[7], 5);
    chk("R2 eeprom contents", {mem[8'h12], mem[8'h13], mem[8'h14], mem[8'h15]}, 32'hA1B2C3D4);
    chk("R11 inactive after stop", status, 0);
  endtask

  task automatic t_read();
    logic [1:0] c;
    clear_log();
    send(1, 16'h0012, 4, c);
    chk("R8 read accepted", c, 0);
    send(0, 16'h0040, 1, c);
    chk("R8 refused while active", c, 3);
    wait_quiet();
    chk("R3/R4 command count", log_n, 9);
    chk("R3 start byte", {log_op[0], log_b[0]}, {3'd1, 8'hA0});
    chk("R3 addr hi", {log_op[1], log_b[1]}, {3'd3, 8'h00});
    chk("R3 addr lo", {log_op[2], log_b[2]}, {3'd3, 8'h12});
    chk("R3 no stop before restart", log_op[3], 2);
    chk("R4 restart byte", log_b[3], 8'hA1);
    chk("R4 read count", count_op(3'd4), 4);
    chk("R4 final stop", log_op[8], 5);
    chk("R5 ack pattern", {log_ack[4], log_ack[5], log_ack[6], log_ack[7]}, 4'b1110);
    chk("R12 byte count", rd_n, 4);
    chk("R12 data order", {rd_cap[0], rd_cap[1], rd_cap[2], rd_cap[3]}, 32'hA1B2C3D4);
    chk("R11 setup/restart/receive seen", seen_stat[4:2], 3'b111);
    chk("R11 inactive after read", status, 0);
  endtask

  task automatic t_retry();
    logic [1:0] c;
    clear_log();
    nack_left = 2;
    send(1, 16'h0013, 2, c);
    chk("R8 retry read accepted", c, 0);
    wait_quiet();
    chk("R6 start attempts", count_op(3'd1), 3);
    chk("R6 nack clears", clr_n, 2);
    chk("R6 stop count", count_op(3'd5), 3);
    chk("R6 data after retry", {rd_cap[0], rd_cap[1]}, 16'hB2C3);
    chk("R6 final status", status, 0);
  endtask

  task automatic t_exhaust();
    logic [1:0] c;
    clear_log();
    nack_left = 100;
    send(1, 16'h0012, 1, c);
    chk("R8 exhaust read accepted", c, 0);
    wait_quiet();
    chk("R7 nack failure status", status, 5);
    chk("R7 start attempts", count_op(3'd1), RMAX + 1);
    chk("R7 no restart", count_op(3'd2), 0);
    chk("R7 no data released", rd_n, 0);
    nack_left = 0;
  endtask

  task automatic t_stop_pending();
    logic [1:0] c;
    int k = 0;
    clear_log();
    stop_lat = 40;
    req_wdata = 64'h5A;
    send(0, 16'h0020, 1, c);
    chk("R8 write accepted", c, 0);
    while (log_n < 5 && k < 200) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
    send(0, 16'h0021, 1, c);
    chk("R9 stop not ready", c, 1);
    chk("R11 write busy until stop", status, 1);
    stop_lat = 3;
    wait_quiet();
    chk("R11 inactive after delayed stop", status, 0);
    chk("R9 refused request issued nothing", log_n, 5);
    chk("R2 single byte written", mem[8'h20], 8'h5A);
  endtask

  task automatic t_bus_busy();
    logic [1:0] c;
    clear_log();
    ext_busy = 1;
    send(0, 16'h0030, 1, c);
    chk("R10 bus busy code", c, 2);
    repeat (10) @(negedge clk);
    chk("R10 no command", log_n, 0);
    ext_busy = 0;
  endtask

  task automatic t_proto();
    logic [1:0] c;
    clear_log();
    inj_ardy = 1;
    repeat (3) @(negedge clk);
    chk("R13 flag set", proto_err, 1);
    wait_quiet();
    chk("R13 stop issued", {log_n[7:0], log_op[0]}, {8'd1, 3'd5});
    chk("R13 status inactive", status, 0);
    req_wdata = 64'h77;
    send(0, 16'h0050, 1, c);
    chk("R13 later request accepted", c, 0);
    wait_quiet();
    chk("R13 flag still set", proto_err, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    req_valid = 0; req_read = 0; req_addr = 0; req_len = 0; req_wdata = 0; ext_busy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write();
    t_read();
    t_retry();
    t_exhaust();
    t_stop_pending();
    t_bus_busy();
    t_proto();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule